// File: doc/BRIEF.md
# Interrupt Event Combiner and Priority Line Router

This block collects 128 peripheral interrupt events and delivers them to the twelve maskable priority inputs of a processor core. Events 0 to 3 are not external inputs. Those numbers name the outputs of four combiners. Each combiner ORs the sticky flags of a 32-event group, subject to a per-event mask. Twelve programmable selectors, one per core priority line, each pick one event number. Values 0 to 3 pick a combiner. Values 4 to 127 route that single event straight to the line. An event picked that way leaves its combiner.

Line index i feeds core priority 4+i, so line 0 is the most urgent and line 11 the least. Every line emits a one-cycle pulse when its selected source turns on. Software uses a plain register port to read and clear flags, set masks and program selectors. Reads are combinational. Writes take effect at the clock edge. Events and pulses are plain level and strobe pins with no handshake, because the core samples them every cycle and never stalls them.

Top module: `irq_event_router`

## Requirements
- R1: After reset every flag reads 0, every mask word reads 0xFFFFFFFF (all events blocked), every selector reads 0 and `irq_out` is 0.
- R2: A 0-to-1 change on `evt_in[e]`, for e from 4 to 127, sets the flag of event e at that clock edge. The flag is bit e mod 32 of flag word e/32 and stays set after the input falls.
- R3: Writing flag word k clears each flag whose data bit is 1 and leaves the rest. When a new rising edge and a clear of the same flag fall in one cycle, the flag stays set.
- R4: Inputs `evt_in[3:0]` are ignored: bits 3:0 of flag word 0 always read 0 and never cause a pulse, even with group 0 unmasked.
- R5: Combiner k outputs the OR of the flags of events 32k to 32k+31 whose mask bit (bit e mod 32 of mask word k) is 0 and which no selector routes directly.
- R6: Selector i holds a 7-bit event number. Values 0 to 3 take combiner 0 to 3 as the source of line i. Values 4 to 127 take that event's flag. Several lines may select the same source.
- R7: While any selector holds event e (e of 4 or more), e's flag is left out of its combiner. When the last such selector moves away, a set flag of e re-enters its combiner.
- R8: Line i pulses high for exactly one cycle when its source goes from 0 to 1. This happens one clock edge after the flag sets, or one edge after a selector write that switches the line to a source already set.
- R9: A line gives no further pulse while its source stays set. It pulses again only after the source has dropped and risen again.
- R10: Register word addresses: 0 to 3 are flag words, 4 to 7 are mask words, 8 to 19 are selectors for lines 0 to 11 in bits 6:0 (upper bits read 0). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 128 | Peripheral event levels, bit e is event e |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_out | output | 12 | One-cycle pulses to core priority lines 4 to 15 |

## Verification
Two functions can land in the same cycle. The first pair is a software clear of a flag and a fresh rising edge of the same event. The bench drives the event high on the same edge as the clear write and expects the flag to read back set. The second pair is a selector write and a change of combiner membership. Unrouting an event whose flag is already set must make that combiner's line pulse exactly one edge after the write, while the line being moved stays quiet.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned EVT_COUNT  = 128;
  localparam int unsigned GROUP_SIZE = 32;
  localparam int unsigned LINE_COUNT = 12;
  localparam int unsigned REG_AW     = 5;

  function automatic int unsigned mask_base(input int unsigned n_grp);
    return n_grp;
  endfunction

  function automatic int unsigned sel_base(input int unsigned n_grp);
    return 2 * n_grp;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_EVT = 128,
  parameter int unsigned N_RSV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_EVT-1:0] clr_v,
  output logic [N_EVT-1:0] flag_q
);
  logic [N_EVT-1:0] evt_q;
  logic [N_EVT-1:0] live;
  logic [N_EVT-1:0] rise_v;

  generate
    for (genvar e = 0; e < N_EVT; e++) begin : g_live
      if (e < N_RSV) begin : g_rsv
        assign live[e] = 1'b0;
      end else begin : g_evt
        assign live[e] = 1'b1;
      end
    end
  endgenerate

  assign rise_v = evt_in & ~evt_q & live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      flag_q <= '0;
    end else begin
      evt_q  <= evt_in;
      flag_q <= (flag_q & ~clr_v) | rise_v;
    end
  end

  // R2: every detected edge leaves its flag set, clear or not
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_v != '0) |=> ((flag_q & $past(rise_v)) == $past(rise_v)));

  // R3: a clear with no competing edge drops the flag
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~rise_v) != '0) |=> ((flag_q & $past(clr_v & ~rise_v)) == '0));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int unsigned N_EVT = 128,
  parameter int unsigned GRP_W = 32,
  parameter int unsigned N_OUT = 12,
  parameter int unsigned SEL_W = 7,
  parameter int unsigned N_GRP = N_EVT / GRP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_EVT-1:0]            flag_q,
  input  logic [N_GRP-1:0][GRP_W-1:0] mask,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel,
  output logic [N_GRP-1:0]            comb
);
  logic [N_EVT-1:0] routed;

  always_comb begin
    routed = '0;
    for (int e = N_GRP; e < N_EVT; e++) begin
      for (int i = 0; i < N_OUT; i++) begin
        if (sel[i] == SEL_W'(e)) routed[e] = 1'b1;
      end
    end
  end

  generate
    for (genvar k = 0; k < N_GRP; k++) begin : g_grp
      assign comb[k] = |(flag_q[k*GRP_W +: GRP_W] & ~mask[k] & ~routed[k*GRP_W +: GRP_W]);

      // R5: a combined event always has an unmasked flag behind it
      a_r5_comb_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        comb[k] |-> ((flag_q[k*GRP_W +: GRP_W] & ~mask[k]) != '0));
    end
  endgenerate
endmodule

// File: rtl/irq_line_select.sv
module irq_line_select #(
  parameter int unsigned N_EVT = 128,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned N_OUT = 12,
  parameter int unsigned SEL_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_EVT-1:0]            flag_q,
  input  logic [N_GRP-1:0]            comb,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel,
  output logic [N_OUT-1:0]            irq_out
);
  localparam int unsigned GI_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  logic [N_OUT-1:0] src;
  logic [N_OUT-1:0] src_q;

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_line
      assign src[i] = (sel[i] < SEL_W'(N_GRP)) ? comb[sel[i][GI_W-1:0]] : flag_q[sel[i]];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      irq_out <= '0;
    end else begin
      src_q   <= src;
      irq_out <= src & ~src_q;
    end
  end

  // R8: no line stays high on two consecutive cycles
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |=> ((irq_out & $past(irq_out)) == '0));

  // R9: a source held high yields no pulse on the following edge
  a_r9_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & src_q) != '0) |=> ((irq_out & $past(src & src_q)) == '0));
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned N_EVT = 128,
  parameter int unsigned GRP_W = 32,
  parameter int unsigned N_OUT = 12,
  parameter int unsigned SEL_W = 7,
  parameter int unsigned AW    = 5,
  parameter int unsigned N_GRP = N_EVT / GRP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [AW-1:0]               reg_addr,
  input  logic [GRP_W-1:0]            reg_wdata,
  input  logic [N_EVT-1:0]            flag_q,
  output logic [GRP_W-1:0]            reg_rdata,
  output logic [N_EVT-1:0]            clr_v,
  output logic [N_GRP-1:0][GRP_W-1:0] mask_q,
  output logic [N_OUT-1:0][SEL_W-1:0] sel_q
);
  localparam int unsigned MASK_B = mask_base(N_GRP);
  localparam int unsigned SEL_B  = sel_base(N_GRP);

  always_comb begin
    clr_v = '0;
    for (int k = 0; k < N_GRP; k++) begin
      if (reg_wr && reg_addr == AW'(k)) clr_v[k*GRP_W +: GRP_W] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sel_q  <= '0;
    end else if (reg_wr) begin
      for (int k = 0; k < N_GRP; k++) begin
        if (reg_addr == AW'(MASK_B + k)) mask_q[k] <= reg_wdata;
      end
      for (int i = 0; i < N_OUT; i++) begin
        if (reg_addr == AW'(SEL_B + i)) sel_q[i] <= reg_wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < N_GRP; k++) begin
      if (reg_addr == AW'(k))          reg_rdata = flag_q[k*GRP_W +: GRP_W];
      if (reg_addr == AW'(MASK_B + k)) reg_rdata = mask_q[k];
    end
    for (int i = 0; i < N_OUT; i++) begin
      if (reg_addr == AW'(SEL_B + i)) reg_rdata = {{(GRP_W-SEL_W){1'b0}}, sel_q[i]};
    end
  end

  generate
    for (genvar k = 0; k < N_GRP; k++) begin : g_mchk
      // R10: a mask write lands whole on the next edge
      a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(MASK_B + k)) |=> (mask_q[k] == $past(reg_wdata)));
    end
    for (genvar i = 0; i < N_OUT; i++) begin : g_schk
      // R6: a selector changes only through its own address
      a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AW'(SEL_B + i)) |=> $stable(sel_q[i]));
    end
  endgenerate
endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_EVT = EVT_COUNT,
  parameter int unsigned GRP_W = GROUP_SIZE,
  parameter int unsigned N_OUT = LINE_COUNT,
  parameter int unsigned AW    = REG_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [GRP_W-1:0] reg_wdata,
  output logic [GRP_W-1:0] reg_rdata,
  output logic [N_OUT-1:0] irq_out
);
  localparam int unsigned N_GRP = N_EVT / GRP_W;
  localparam int unsigned SEL_W = $clog2(N_EVT);

  logic [N_EVT-1:0]            flag_q;
  logic [N_EVT-1:0]            clr_v;
  logic [N_GRP-1:0][GRP_W-1:0] mask_q;
  logic [N_OUT-1:0][SEL_W-1:0] sel_q;
  logic [N_GRP-1:0]            comb;

  irq_router_regs #(
    .N_EVT(N_EVT), .GRP_W(GRP_W), .N_OUT(N_OUT), .SEL_W(SEL_W), .AW(AW), .N_GRP(N_GRP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .flag_q(flag_q), .reg_rdata(reg_rdata),
    .clr_v(clr_v), .mask_q(mask_q), .sel_q(sel_q)
  );

  irq_flag_bank #(.N_EVT(N_EVT), .N_RSV(N_GRP)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_v(clr_v), .flag_q(flag_q)
  );

  irq_combiner #(
    .N_EVT(N_EVT), .GRP_W(GRP_W), .N_OUT(N_OUT), .SEL_W(SEL_W), .N_GRP(N_GRP)
  ) u_comb (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .mask(mask_q), .sel(sel_q), .comb(comb)
  );

  irq_line_select #(.N_EVT(N_EVT), .N_GRP(N_GRP), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .comb(comb), .sel(sel_q), .irq_out(irq_out)
  );
endmodule

// File: tb/sim_irq_event_router.sv
`timescale 1ns/1ps
module sim_irq_event_router;
  localparam int AW = 5;
  localparam int NL = 12;
  localparam int MB = 4;
  localparam int SB = 8;

  // {line, selector value, event}
  localparam logic [17:0] VEC [8] = '{
    {4'd0,  7'd4,   7'd4},
    {4'd11, 7'd127, 7'd127},
    {4'd5,  7'd64,  7'd64},
    {4'd3,  7'd0,   7'd5},
    {4'd7,  7'd1,   7'd33},
    {4'd9,  7'd2,   7'd95},
    {4'd2,  7'd3,   7'd96},
    {4'd10, 7'd3,   7'd127}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [127:0]  evt_in = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int sel_sh [NL];

  always #2.5 clk = ~clk;

  irq_event_router u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_sel(input int line, input int v);
    wr(SB + line, 32'(v));
    sel_sh[line] = v;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [NL-1:0] lines_of(input int v);
    logic [NL-1:0] m = '0;
    for (int j = 0; j < NL; j++) if (sel_sh[j] == v) m[j] = 1'b1;
    return m;
  endfunction

  task automatic fire_expect(input int e, input logic [NL-1:0] exp, input string req);
    @(negedge clk); evt_in[e] = 1'b1;
    @(negedge clk); check({req, " before pulse"}, 32'(irq_out), 32'h0);
    @(negedge clk); check({req, " pulse"}, 32'(irq_out), 32'(exp));
    @(negedge clk); check({req, " after pulse"}, 32'(irq_out), 32'h0);
    evt_in[e] = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int line, s, e;
    line = int'(VEC[v][17:14]); s = int'(VEC[v][13:7]); e = int'(VEC[v][6:0]);
    wr_sel(line, s);
    if (s < 4) wr(MB + s, ~(32'h1 << (e % 32)));
    fire_expect(e, lines_of(s), (s < 4) ? "R5 R6 combiner" : "R6 direct");
    wr(e / 32, 32'h1 << (e % 32));
    if (s < 4) wr(MB + s, 32'hFFFF_FFFF);
    wr_sel(line, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int j = 0; j < NL; j++) sel_sh[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 map
    for (int k = 0; k < 4; k++) begin
      rd(k, d);      check("R1 flag word", d, 32'h0);
      rd(MB + k, d); check("R1 mask word", d, 32'hFFFF_FFFF);
    end
    rd(SB, d);      check("R1 selector 0", d, 32'h0);
    rd(SB + 11, d); check("R1 selector 11", d, 32'h0);
    check("R1 irq_out", 32'(irq_out), 32'h0);
    rd(20, d); check("R10 unused addr 20", d, 32'h0);
    rd(31, d); check("R10 unused addr 31", d, 32'h0);
    wr(SB + 9, 32'hFFFF_FFFF);
    rd(SB + 9, d); check("R10 selector width", d, 32'h7F);
    wr(SB + 9, 32'h0);

    // table walk: R6 with direct and combiner sources
    for (int v = 0; v < 8; v++) run_vec(v);

    // R2 sticky flag
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk); rd(1, d); check("R2 flag set", d, 32'h100);
    evt_in[40] = 1'b0;
    @(negedge clk); rd(1, d); check("R2 flag sticky", d, 32'h100);

    // R3 clear semantics
    wr(1, 32'h0); rd(1, d); check("R3 zero write keeps", d, 32'h100);
    wr(1, 32'h100); rd(1, d); check("R3 one write clears", d, 32'h0);
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk); evt_in[40] = 1'b0;
    @(negedge clk);
    evt_in[40] = 1'b1; reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 32'h100;
    @(negedge clk); reg_wr = 1'b0; evt_in[40] = 1'b0;
    rd(1, d); check("R3 edge beats clear", d, 32'h100);
    wr(1, 32'h100); rd(1, d); check("R3 cleared again", d, 32'h0);

    // R4 reserved inputs ignored
    wr(MB, 32'h0);
    @(negedge clk); evt_in[3:0] = 4'hF;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); check("R4 no pulse", 32'(irq_out), 32'h0);
    end
    rd(0, d); check("R4 flag word 0", d, 32'h0);
    evt_in[3:0] = 4'h0;
    wr(MB, 32'hFFFF_FFFF);

    // R7 direct routing removes the event from its combiner
    wr_sel(4, 50); wr_sel(5, 1);
    wr(MB + 1, 32'h0);
    fire_expect(50, 12'h010, "R7 routed only");
    fire_expect(51, 12'h020, "R7 combiner other member");
    wr(1, 32'h0008_0000);
    wr_sel(4, 0);
    check("R7 unroute write", 32'(irq_out), 32'h0);
    @(negedge clk); check("R7 rejoin pulse", 32'(irq_out), 32'h020);
    @(negedge clk); check("R7 rejoin single", 32'(irq_out), 32'h0);
    wr(1, 32'h0004_0000);
    wr(MB + 1, 32'hFFFF_FFFF);
    wr_sel(5, 0);

    // R8 switching onto an already-set source
    @(negedge clk); evt_in[70] = 1'b1;
    @(negedge clk); evt_in[70] = 1'b0;
    wr_sel(6, 70);
    check("R8 switch write", 32'(irq_out), 32'h0);
    @(negedge clk); check("R8 switch pulse", 32'(irq_out), 32'h040);

    // R9 held source stays quiet, re-arms after drop
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); check("R9 held quiet", 32'(irq_out), 32'h0);
    end
    evt_in[70] = 1'b1;
    wr(2, 32'h40);
    check("R9 clear while input high", 32'(irq_out), 32'h0);
    evt_in[70] = 1'b0;
    fire_expect(70, 12'h040, "R9 re-armed");
    wr(2, 32'h40);
    wr_sel(6, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule